// File: doc/BRIEF.md
# Call/Return Program Sequencer with Link Stack

This block produces the program counter for a byte-addressed machine with 32-bit words. Each accepted operation code chooses the next PC. It can step to the next word, take a branch when a condition is met, enter a subroutine or return from one. A subroutine call writes the return address into a link register.

Nested calls need the link value to survive a deeper call. Two further operations handle this. One spills the link register onto a memory stack that grows toward lower addresses. The other reloads the link register from the top of that stack. Both spills and reloads go through a simple request/response memory port. A reload finishes only when its read data arrives.

While a memory access is in flight the sequencer reports busy. The PC, link register and stack pointer do not move during that time, and new operations are not accepted. A spill that would take the stack pointer below a configured floor is refused and raises a sticky overflow flag.

Top module: `callret_seq`

## Requirements
- R1: After a clock edge with `rst_n` low: `pc` = RESET_PC, `link` = 0, `sp` = STACK_TOP, and `overflow`, `busy` and `mem_req` are all 0.
- R2: An accepted op code 0 (step) adds 4 to `pc`. The unused codes 6 and 7 act as code 0. An operation is accepted when `op_valid` is 1 and `busy` is 0 at a rising edge.
- R3: An accepted op code 1 (branch) loads `target` into `pc` when `cond` is 1. When `cond` is 0 it adds 4 to `pc`.
- R4: An accepted op code 2 (call) loads the old `pc` + 4 into `link` and `target` into `pc`, both in the same edge.
- R5: An accepted op code 3 (return) loads `link` into `pc`.
- R6: An accepted op code 4 (spill) with `sp` - 4 >= STACK_LIMIT lowers `sp` by 4 in the accepting edge. It then holds a write request (`mem_req`=1, `mem_we`=1) with `mem_addr` = new `sp` and `mem_wdata` = `link`. At the edge where `mem_done` is seen, `pc` advances by 4.
- R7: An accepted op code 5 (reload) holds a read request (`mem_req`=1, `mem_we`=0) at `mem_addr` = `sp`. At the edge where `mem_done` is seen, `link` takes `mem_rdata`, `sp` rises by 4 and `pc` advances by 4.
- R8: While `busy` is 1 and `mem_done` is 0, `pc`, `link`, `sp` and the request fields hold. Operations offered while busy are dropped, including one offered in the cycle the response arrives.
- R9: A spill with `sp` - 4 < STACK_LIMIT issues no memory request and leaves `sp` unchanged. It sets `overflow`, which stays 1 until reset, and advances `pc` by 4. `sp` never goes below STACK_LIMIT.
- R10: Link values spilled at increasing call depth come back in reverse order. A nest of calls unwound by reload/return pairs ends at the instruction after the outermost call.
- R11: With `op_valid` at 0 and no access in flight, `pc`, `link` and `sp` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| op | input | 3 | Operation code (0 step, 1 branch, 2 call, 3 return, 4 spill, 5 reload) |
| target | input | AW | Branch or call destination |
| cond | input | 1 | Branch condition |
| mem_rdata | input | AW | Read data from the stack memory |
| mem_done | input | 1 | Memory response for the current request |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the stack word |
| mem_wdata | output | AW | Link value being spilled |
| pc | output | AW | Program counter |
| link | output | AW | Link register |
| sp | output | AW | Stack pointer |
| busy | output | 1 | Memory access in flight |
| overflow | output | 1 | Sticky spill-refused flag |

## Verification
The edge that completes a memory access can coincide with a new operation, because the bench's memory response and an offered branch meet at the same edge. During each reload the bench keeps `op_valid` high and swaps the code to a taken branch, then releases it only once `busy` has dropped. The check then requires that the PC advanced by exactly 4 and never jumped to the branch target. This is repeated for memory latencies of one, two and three cycles.

// File: rtl/callret_pkg.sv
// Shared op codes and stack-controller states for the call/return sequencer.
// Assumes a 3-bit operation field.
package callret_pkg;
    localparam logic [2:0] OP_STEP   = 3'd0;
    localparam logic [2:0] OP_BRANCH = 3'd1;
    localparam logic [2:0] OP_CALL   = 3'd2;
    localparam logic [2:0] OP_RET    = 3'd3;
    localparam logic [2:0] OP_SPILL  = 3'd4;
    localparam logic [2:0] OP_RELOAD = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } stk_state_e;
endpackage

// File: rtl/callret_flow.sv
// Next-PC selector for the non-memory operations (step, branch, call, return).
// Purely combinational. Assumes byte addressing with AW/8-byte words.
module callret_flow
    import callret_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [2:0]    op,
    input  logic          cond,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] link,
    output logic [AW-1:0] flow_pc,
    output logic [AW-1:0] ret_addr,
    output logic          is_mem_op
);
    localparam logic [AW-1:0] WORD_B = AW'(AW / 8);

    // Choose the next PC for the operation and form the return address.
    always_comb begin
        ret_addr = pc + WORD_B;
        flow_pc  = ret_addr;
        case (op)
            OP_BRANCH: if (cond) flow_pc = target;
            OP_CALL:   flow_pc = target;
            OP_RET:    flow_pc = link;
            default:   flow_pc = ret_addr;
        endcase
        is_mem_op = (op == OP_SPILL) || (op == OP_RELOAD);
    end
endmodule

// File: rtl/callret_stack.sv
// Stack pointer and memory-port controller for spilling and reloading the link
// register. The stack grows downward. A spill pre-decrements the pointer and a
// reload post-increments it. Assumes start_* pulses arrive only while idle.
module callret_stack
    import callret_pkg::*;
#(
    parameter int            AW          = 32,
    parameter logic [AW-1:0] STACK_TOP   = 32'h0000_1000,
    parameter logic [AW-1:0] STACK_LIMIT = 32'h0000_0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_push,
    input  logic          start_pop,
    input  logic [AW-1:0] link_in,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_done,
    output logic [AW-1:0] sp,
    output logic          busy,
    output logic          step,
    output logic          pop_load,
    output logic [AW-1:0] pop_data,
    output logic          overflow,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata
);
    localparam logic [AW-1:0] WORD_B     = AW'(AW / 8);
    localparam logic [AW-1:0] PUSH_FLOOR = STACK_LIMIT + WORD_B;

    stk_state_e    state;
    logic [AW-1:0] wdata_q;
    logic          room;

    // Room check: a spill may proceed only if sp - word stays at or above the limit.
    assign room = (sp >= PUSH_FLOOR);

    // Sequence the spill/reload accesses and keep the pointer and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sp       <= STACK_TOP;
            overflow <= 1'b0;
            wdata_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_push) begin
                        if (room) begin
                            sp      <= sp - WORD_B;
                            wdata_q <= link_in;
                            state   <= ST_WRITE;
                        end else begin
                            overflow <= 1'b1;
                        end
                    end else if (start_pop) begin
                        state <= ST_READ;
                    end
                end
                ST_WRITE: if (mem_done) state <= ST_IDLE;
                ST_READ: begin
                    if (mem_done) begin
                        sp    <= sp + WORD_B;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port and the completion strobes from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = busy;
        mem_we    = (state == ST_WRITE);
        mem_addr  = sp;
        mem_wdata = wdata_q;
        pop_load  = (state == ST_READ) && mem_done;
        pop_data  = mem_rdata;
        step      = (busy && mem_done) || ((state == ST_IDLE) && start_push && !room);
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    sp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp >= STACK_LIMIT);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R7
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && mem_done) |=> (sp == $past(sp) + WORD_B));
endmodule

// File: rtl/callret_seq.sv
// Call/return program sequencer: holds the PC and link register. It accepts
// one operation per cycle when idle and hands spill/reload to the stack
// controller. Assumes the memory answers each request with one mem_done pulse.
module callret_seq
    import callret_pkg::*;
#(
    parameter int            AW          = 32,
    parameter logic [AW-1:0] RESET_PC    = 32'h0000_0000,
    parameter logic [AW-1:0] STACK_TOP   = 32'h0000_1000,
    parameter logic [AW-1:0] STACK_LIMIT = 32'h0000_0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op,
    input  logic [AW-1:0] target,
    input  logic          cond,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] link,
    output logic [AW-1:0] sp,
    output logic          busy,
    output logic          overflow
);
    localparam logic [AW-1:0] WORD_B = AW'(AW / 8);

    logic          accept, flow_take, start_push, start_pop;
    logic          step, pop_load, is_mem_op;
    logic [AW-1:0] flow_pc, ret_addr, pop_data;

    // Accept an offered operation only while no access is in flight.
    always_comb begin
        accept     = op_valid && !busy;
        flow_take  = accept && !is_mem_op;
        start_push = accept && (op == OP_SPILL);
        start_pop  = accept && (op == OP_RELOAD);
    end

    callret_flow #(.AW(AW)) u_flow (
        .op        (op),
        .cond      (cond),
        .target    (target),
        .pc        (pc),
        .link      (link),
        .flow_pc   (flow_pc),
        .ret_addr  (ret_addr),
        .is_mem_op (is_mem_op)
    );

    callret_stack #(
        .AW          (AW),
        .STACK_TOP   (STACK_TOP),
        .STACK_LIMIT (STACK_LIMIT)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_push (start_push),
        .start_pop  (start_pop),
        .link_in    (link),
        .mem_rdata  (mem_rdata),
        .mem_done   (mem_done),
        .sp         (sp),
        .busy       (busy),
        .step       (step),
        .pop_load   (pop_load),
        .pop_data   (pop_data),
        .overflow   (overflow),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    // Update the PC from flow operations or on completion of a stack operation.
    always_ff @(posedge clk) begin
        if (!rst_n)         pc <= RESET_PC;
        else if (flow_take) pc <= flow_pc;
        else if (step)      pc <= pc + WORD_B;
    end

    // Load the link register on a call or when a reload's data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                            link <= '0;
        else if (flow_take && op == OP_CALL)   link <= ret_addr;
        else if (pop_load)                     link <= pop_data;
    end

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_done) |=> ($stable(pc) && $stable(link) && $stable(sp)));

    // R4
    call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op == OP_CALL) |=> (link == $past(pc) + WORD_B && pc == $past(target)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !busy) |=> ($stable(pc) && $stable(link) && $stable(sp)));
endmodule

// File: tb/callret_seq_bench.sv
// Self-checking bench: sweeps all op codes, branch conditions, nesting up to
// the stack depth, overflow and idle cycles at memory latencies of 1 to 3.
module callret_seq_bench;
    localparam int          AW    = 32;
    localparam logic [31:0] RPC   = 32'h0000_0000;
    localparam logic [31:0] TOP   = 32'h0000_0100;
    localparam logic [31:0] LIMIT = 32'h0000_00F0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [31:0]   target = '0;
    logic          cond = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          mem_done = 1'b0;
    logic          mem_req, mem_we, busy, overflow;
    logic [31:0]   mem_addr, mem_wdata, pc, link, sp;

    int tests = 0;
    int fails = 0;
    int lat = 1;
    int cnt = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] mem [64];
    logic [31:0] exp_mem [64];
    logic [31:0] e_pc, e_link, e_sp;
    logic        e_ovf;

    always #10 clk = ~clk;

    callret_seq #(
        .AW(AW), .RESET_PC(RPC), .STACK_TOP(TOP), .STACK_LIMIT(LIMIT)
    ) u_callret_seq (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .target(target),
        .cond(cond), .mem_rdata(mem_rdata), .mem_done(mem_done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc(pc),
        .link(link), .sp(sp), .busy(busy), .overflow(overflow)
    );

    // Stack memory model with a programmable response latency.
    always @(negedge clk) begin
        if (mem_req && !mem_done) begin
            if (cnt + 1 >= lat) begin
                mem_done <= 1'b1;
                cnt      <= 0;
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:2]];
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            mem_done <= 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "pc", pc, e_pc);
        check(tag, "link", link, e_link);
        check(tag, "sp", sp, e_sp);
        check(tag, "overflow", {31'd0, overflow}, {31'd0, e_ovf});
        check(tag, "busy", {31'd0, busy}, 32'd0);
    endtask

    // Offer one operation, follow any memory access, update the model, compare.
    task automatic run_op(input logic [2:0] o, input logic [31:0] t,
                          input logic c, input string tag);
        logic [31:0] pc0;
        pc0 = pc;
        @(negedge clk);
        op_valid = 1'b1; op = o; target = t; cond = c;
        @(negedge clk);
        if (o == 3'd4 || o == 3'd5) begin
            if (o == 3'd4 && e_sp < LIMIT + 32'd4) begin
                check("R9", "no request on refused spill", {31'd0, mem_req}, 32'd0);
            end else begin
                check(tag, "mem_req", {31'd0, mem_req}, 32'd1);
                check(tag, "mem_we", {31'd0, mem_we}, {31'd0, (o == 3'd4)});
                check(tag, "mem_addr", mem_addr, (o == 3'd4) ? e_sp - 32'd4 : e_sp);
                if (o == 3'd4) check("R6", "mem_wdata", mem_wdata, e_link);
                // Same-cycle case: a taken branch is offered for the whole access.
                op = 3'd1; target = 32'h0000_0FFC; cond = 1'b1;
                while (busy) begin
                    check("R8", "pc held while busy", pc, pc0);
                    @(negedge clk);
                end
            end
        end
        op_valid = 1'b0;
        case (o)
            3'd1: e_pc = c ? t : e_pc + 32'd4;
            3'd2: begin e_link = e_pc + 32'd4; e_pc = t; end
            3'd3: e_pc = e_link;
            3'd4: begin
                if (e_sp >= LIMIT + 32'd4) begin
                    e_sp = e_sp - 32'd4;
                    exp_mem[e_sp[7:2]] = e_link;
                end else begin
                    e_ovf = 1'b1;
                end
                e_pc = e_pc + 32'd4;
            end
            3'd5: begin
                e_link = exp_mem[e_sp[7:2]];
                e_sp   = e_sp + 32'd4;
                e_pc   = e_pc + 32'd4;
            end
            default: e_pc = e_pc + 32'd4;
        endcase
        check_all(tag);
    endtask

    initial begin
        logic [31:0] p0;
        for (int l = 1; l <= 3; l++) begin
            lat = l;
            rst_n = 1'b0; op_valid = 1'b0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            e_pc = RPC; e_link = '0; e_sp = TOP; e_ovf = 1'b0;
            // R1 reset state
            check_all("R1");
            check("R1", "mem_req", {31'd0, mem_req}, 32'd0);

            // R2 step, including unused codes
            run_op(3'd0, 32'h0, 1'b0, "R2");
            run_op(3'd6, 32'h0, 1'b1, "R2");
            run_op(3'd7, 32'h0, 1'b0, "R2");

            // R3 branch sweep over condition and targets
            for (int i = 0; i < 4; i++)
                run_op(3'd1, 32'h40 + 32'(i) * 32'h10, i[0], "R3");

            // R4 call then R5 return
            run_op(3'd2, 32'h200, 1'b0, "R4");
            run_op(3'd3, 32'h0, 1'b0, "R5");

            // R10 nesting to full depth with spills, then unwind
            p0 = e_pc;
            for (int d = 0; d < 4; d++) begin
                run_op(3'd2, 32'h300 + 32'(d) * 32'h40, 1'b0, "R4");
                run_op(3'd4, 32'h0, 1'b0, "R6");
            end
            for (int d = 0; d < 4; d++) begin
                run_op(3'd5, 32'h0, 1'b0, "R7");
                run_op(3'd3, 32'h0, 1'b0, "R10");
            end
            check("R10", "outermost return", pc, p0 + 32'd4);

            // R9 overflow on the fifth spill, sticky through reloads
            for (int k = 0; k < 5; k++) run_op(3'd4, 32'h0, 1'b0, "R9");
            for (int k = 0; k < 4; k++) run_op(3'd5, 32'h0, 1'b0, "R9");
            check("R9", "sp back at top", sp, TOP);

            // R11 idle cycles
            repeat (5) @(negedge clk);
            check_all("R11");
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule